// File: doc/BRIEF.md
# Flash Command Decoder with Embedded Program/Erase Timing

This block is a synthesizable device-side model of a byte-wide parallel flash memory. It watches a host-style asynchronous bus (active-low chip enable, write enable and output enable, plus an address and a data-in byte), all sampled on a system clock. A write is captured when write enable returns high while chip enable is low. Only writes that follow a fixed two-write unlock prefix can form a command. Three commands exist: byte program, chip erase and sector erase. Sector erase can take several sectors in one operation.

Once a command is accepted, the block runs an embedded operation for a parameterised number of clock cycles. The real microsecond and second durations are scaled down to cycle counts. Reads during this time return a polling status byte instead of array data. The on-chip storage array is small and parameterised. It is split into eight equal sectors, selected by the top address bits.

The unlock addresses are the low `ADDR_W` bits of 5555h and 2AAAh. With the default `ADDR_W` of 11, these are 555h and 2AAh.

Top module: `flash_cmd_top`

## Requirements
- R1: After reset every array byte reads FFh, and `dout` is FFh in any cycle that follows a clock edge where `ce_n` or `oe_n` was high.
- R2: With `ce_n` and `oe_n` low and no operation running, `dout` shows the array byte at `addr` one clock edge later.
- R3: A command begins only with data AAh at address 555h, followed by data 55h at address 2AAh. Any other write in these positions, or in the later command positions, returns the decoder to read mode and leaves the array unchanged.
- R4: Byte program is AAh/555h, 55h/2AAh, A0h/555h, then the data written to the target address. The stored byte becomes the old value AND the new data.
- R5: A program runs for `PROG_CYC` cycles. Reads meanwhile return bit 7 equal to the inverse of the programmed data's bit 7, and bits 6..0 equal to 0. After the program finishes, reads return the stored byte.
- R6: Chip erase is AAh/555h, 55h/2AAh, 80h/555h, AAh/555h, 55h/2AAh, 10h/555h. It sets every byte to FFh. While it runs, reads return bit 7 = 0.
- R7: Sector erase uses the same first five writes, then 30h at any address of a sector. The sector is `addr[ADDR_W-1:ADDR_W-3]`. Further 30h writes within `WIN_CYC` cycles of the first add their sectors. When the window ends, all collected sectors are erased, and bytes in other sectors are kept.
- R8: A write with data other than 30h during the sector-collection window cancels the erase.
- R9: Writes arriving while an operation runs have no effect on the array or on the decoder.
- R10: A sector erase stays busy for max(`SECT_CYC`, array depth) cycles after the window closes, and a chip erase for max(`CHIP_CYC`, array depth) cycles.
- R11: A write enable pulse while `ce_n` is high is not a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write is taken on its rising edge |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or polling status |

## Verification
The bench programs a byte whose bit 7 is 1. A design that polled the stored value, rather than the inverted target bit, would show 1 instead of 0 during the busy time. A second program onto the same byte exposes a design that overwrites instead of ANDing.

The bench breaks the unlock prefix by a single address bit, then issues a correct command. This catches a decoder that ignores the address, and one that stays stuck after an abort.

Two sectors are erased in one window while a third sector is watched for stray clearing. A foreign write inside the window must cancel the erase.

A full program sequence is sent during a chip erase. A decoder that keeps listening while busy would leave 00h where FFh is expected.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_READ,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_ERA3,
    ST_ERA4,
    ST_ERA5,
    ST_SWIN,
    ST_BUSY
  } cmd_st_e;

  localparam logic [7:0]  D_UNL1  = 8'hAA;
  localparam logic [7:0]  D_UNL2  = 8'h55;
  localparam logic [7:0]  D_PROG  = 8'hA0;
  localparam logic [7:0]  D_ERASE = 8'h80;
  localparam logic [7:0]  D_CHIP  = 8'h10;
  localparam logic [7:0]  D_SECT  = 8'h30;
  localparam logic [15:0] A_UNL1  = 16'h5555;
  localparam logic [15:0] A_UNL2  = 16'h2AAA;

endpackage

// File: rtl/flash_bus_sniff.sv
module flash_bus_sniff #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);

  logic we_q;

  // A write is taken when write enable returns high with chip enable low.
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b1;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      we_q   <= we_n;
      wr_stb <= we_n & ~we_q & ~ce_n;
      if (we_n & ~we_q & ~ce_n) begin
        wr_addr <= addr;
        wr_data <= din;
      end
    end
  end

endmodule

// File: rtl/flash_store.sv
module flash_store #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [7:0]        rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [7:0]        rdata_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int SECT_W   = 3,
  parameter int PROG_CYC = 14,
  parameter int SECT_CYC = 3000,
  parameter int CHIP_CYC = 6000,
  parameter int WIN_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [7:0]        old_data,
  output logic              busy,
  output logic              busy_prog,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [7:0]        prog_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NSECT  = 1 << SECT_W;
  localparam int SECT_T = (SECT_CYC > DEPTH) ? SECT_CYC : DEPTH;
  localparam int CHIP_T = (CHIP_CYC > DEPTH) ? CHIP_CYC : DEPTH;
  localparam int TMR_W  = $clog2(CHIP_T + SECT_T + PROG_CYC + WIN_CYC + 1);
  localparam logic [ADDR_W-1:0] UA1 = A_UNL1[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] UA2 = A_UNL2[ADDR_W-1:0];

  cmd_st_e            st;
  logic [TMR_W-1:0]   tmr;
  logic [NSECT-1:0]   mask;
  logic [ADDR_W:0]    walk;
  logic [SECT_W-1:0]  wr_sect;
  logic [NSECT-1:0]   sect_bit;
  logic               hit1, hit2, at_u1, last_tick;

  assign wr_sect   = wr_addr[ADDR_W-1 -: SECT_W];
  assign sect_bit  = NSECT'(1) << wr_sect;
  assign at_u1     = (wr_addr == UA1);
  assign hit1      = at_u1 && (wr_data == D_UNL1);
  assign hit2      = (wr_addr == UA2) && (wr_data == D_UNL2);
  assign last_tick = (tmr == TMR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_READ;
      tmr       <= '0;
      mask      <= '0;
      walk      <= '0;
      busy_prog <= 1'b0;
      tgt_addr  <= '0;
      prog_data <= '0;
    end else begin
      case (st)
        ST_READ: if (wr_stb) st <= hit1 ? ST_UNL1 : ST_READ;
        ST_UNL1: if (wr_stb) st <= hit2 ? ST_UNL2 : ST_READ;
        ST_UNL2: if (wr_stb) begin
          if (at_u1 && wr_data == D_PROG)       st <= ST_PROG;
          else if (at_u1 && wr_data == D_ERASE) st <= ST_ERA3;
          else                                  st <= ST_READ;
        end
        ST_PROG: if (wr_stb) begin
          st        <= ST_BUSY;
          busy_prog <= 1'b1;
          tgt_addr  <= wr_addr;
          prog_data <= wr_data;
          tmr       <= TMR_W'(PROG_CYC);
        end
        ST_ERA3: if (wr_stb) st <= hit1 ? ST_ERA4 : ST_READ;
        ST_ERA4: if (wr_stb) st <= hit2 ? ST_ERA5 : ST_READ;
        ST_ERA5: if (wr_stb) begin
          if (at_u1 && wr_data == D_CHIP) begin
            st        <= ST_BUSY;
            busy_prog <= 1'b0;
            mask      <= '1;
            walk      <= '0;
            tmr       <= TMR_W'(CHIP_T);
          end else if (wr_data == D_SECT) begin
            st   <= ST_SWIN;
            mask <= sect_bit;
            tmr  <= TMR_W'(WIN_CYC);
          end else begin
            st <= ST_READ;
          end
        end
        ST_SWIN: begin
          if (wr_stb && wr_data != D_SECT) begin
            st <= ST_READ;
          end else begin
            if (wr_stb) mask <= mask | sect_bit;
            if (last_tick) begin
              st        <= ST_BUSY;
              busy_prog <= 1'b0;
              walk      <= '0;
              tmr       <= TMR_W'(SECT_T);
            end else begin
              tmr <= tmr - TMR_W'(1);
            end
          end
        end
        ST_BUSY: begin
          if (!walk[ADDR_W]) walk <= walk + (ADDR_W+1)'(1);
          if (last_tick) st <= ST_READ;
          tmr <= tmr - TMR_W'(1);
        end
        default: st <= ST_READ;
      endcase
    end
  end

  assign busy      = (st == ST_BUSY);
  assign mem_we    = busy && (busy_prog ? last_tick
                                        : (!walk[ADDR_W] && mask[walk[ADDR_W-1 -: SECT_W]]));
  assign mem_waddr = busy_prog ? tgt_addr : walk[ADDR_W-1:0];
  assign mem_wdata = busy_prog ? (old_data & prog_data) : 8'hFF;

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top #(
  parameter int ADDR_W   = 11,
  parameter int SECT_W   = 3,
  parameter int PROG_CYC = 14,
  parameter int SECT_CYC = 3000,
  parameter int CHIP_CYC = 6000,
  parameter int WIN_CYC  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout
);

  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              busy, busy_prog, mem_we;
  logic [ADDR_W-1:0] tgt_addr, mem_waddr;
  logic [7:0]        prog_data, mem_wdata, rdata_a, rdata_b;
  logic              rd_q, busy_q;
  logic [7:0]        stat_q;

  flash_bus_sniff #(.ADDR_W(ADDR_W)) u_sniff (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  flash_cmd_fsm #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC), .WIN_CYC(WIN_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .old_data(rdata_b), .busy(busy), .busy_prog(busy_prog), .tgt_addr(tgt_addr),
    .prog_data(prog_data), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  flash_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(addr), .rdata_a(rdata_a), .raddr_b(tgt_addr), .rdata_b(rdata_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
      stat_q <= 8'h00;
    end else begin
      rd_q   <= ~ce_n & ~oe_n;
      busy_q <= busy;
      stat_q <= {~(busy_prog ? prog_data[7] : 1'b1), 7'b0};
    end
  end

  assign dout = rd_q ? (busy_q ? stat_q : rdata_a) : 8'hFF;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic [7:0]        dout,
  input logic              busy,
  input logic              busy_prog,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic [7:0]        prog_data
);

  AST_IDLE_DOUT: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n) |=> dout == 8'hFF); // R1

  AST_POLL_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    (busy && !ce_n && !oe_n) |=> dout[6:0] == 7'h00); // R5

  AST_POLL_PROG_BIT7: assert property (@(posedge clk) disable iff (rst)
    (busy && busy_prog && !ce_n && !oe_n) |=> dout[7] != prog_data[7]); // R5

  AST_POLL_ERASE_BIT7: assert property (@(posedge clk) disable iff (rst)
    (busy && !busy_prog && !ce_n && !oe_n) |=> !dout[7]); // R6

  AST_PROG_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && busy_prog) |-> $past(wr_stb)); // R4

  AST_BUSY_HOLDS_TARGET: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(tgt_addr) && $stable(prog_data))); // R9

endmodule

bind flash_cmd_top flash_cmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .dout(dout),
  .busy(busy), .busy_prog(busy_prog), .wr_stb(wr_stb),
  .tgt_addr(tgt_addr), .prog_data(prog_data)
);

// File: tb/sim_flash_cmd_top.sv
module sim_flash_cmd_top;

  localparam int AW       = 11;
  localparam int PROG_CYC = 14;
  localparam int SECT_CYC = 3000;
  localparam int CHIP_CYC = 6000;
  localparam int WIN_CYC  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_cmd_top #(
    .ADDR_W(AW), .SECT_W(3), .PROG_CYC(PROG_CYC),
    .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC), .WIN_CYC(WIN_CYC)
  ) u0 (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk); ce_n = ~sel; addr = a; din = d; we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); v = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  // Reads continuously; returns the first sample and the poll index at which exp appeared.
  task automatic poll(input logic [AW-1:0] a, input logic [7:0] exp, input int lim,
                      output logic [7:0] first, output int k_hit);
    k_hit = 0;
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (k == 1) first = dout;
      if (dout == exp) begin k_hit = k; break; end
    end
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic cmd_prog(input logic [AW-1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    bus_wr(11'h555, 8'hAA, sel);
    bus_wr(11'h2AA, 8'h55, sel);
    bus_wr(11'h555, 8'hA0, sel);
    bus_wr(a, d, sel);
  endtask

  task automatic erase_prefix();
    bus_wr(11'h555, 8'hAA);
    bus_wr(11'h2AA, 8'h55);
    bus_wr(11'h555, 8'h80);
    bus_wr(11'h555, 8'hAA);
    bus_wr(11'h2AA, 8'h55);
  endtask

  task automatic prog_wait(input logic [AW-1:0] a, input logic [7:0] d, input logic [7:0] exp);
    logic [7:0] f; int k;
    cmd_prog(a, d);
    poll(a, exp, 200, f, k);
    check("R4 program result", (k > 0) ? exp : dout, exp);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    check("R1 idle dout", dout, 8'hFF);
    rd(11'h000, v); check("R1 erased at start", v, 8'hFF);
    rd(11'h7FF, v); check("R1 erased at top", v, 8'hFF);
  endtask

  task automatic t_ce_high();
    logic [7:0] v;
    cmd_prog(11'h030, 8'h00, 1'b0);
    repeat (PROG_CYC + 5) @(negedge clk);
    rd(11'h030, v); check("R11 write with ce_n high ignored", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] f, v; int k;
    cmd_prog(11'h123, 8'hA5);
    poll(11'h123, 8'hA5, 200, f, k);
    check("R5 busy status byte", f, 8'h00);
    n_chk++;
    if (k < PROG_CYC || k > PROG_CYC + 2) begin
      n_bad++;
      $display("FAIL R5 program duration: actual %0d expected %0d..%0d", k, PROG_CYC, PROG_CYC + 2);
    end
    rd(11'h123, v); check("R2 read after program", v, 8'hA5);
    cmd_prog(11'h123, 8'h5A);
    poll(11'h123, 8'h00, 200, f, k);
    check("R5 status bit7 inverted", f, 8'h80);
    rd(11'h123, v); check("R4 program ANDs old and new", v, 8'h00);
    prog_wait(11'h124, 8'hF0, 8'hF0);
    prog_wait(11'h124, 8'h3C, 8'h30);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    bus_wr(11'h555, 8'hAA); bus_wr(11'h2AB, 8'h55);
    bus_wr(11'h555, 8'hA0); bus_wr(11'h040, 8'h00);
    repeat (PROG_CYC + 5) @(negedge clk);
    rd(11'h040, v); check("R3 wrong unlock address", v, 8'hFF);
    bus_wr(11'h555, 8'hAA); bus_wr(11'h2AA, 8'h56);
    bus_wr(11'h555, 8'hA0); bus_wr(11'h040, 8'h00);
    repeat (PROG_CYC + 5) @(negedge clk);
    rd(11'h040, v); check("R3 wrong unlock data", v, 8'hFF);
    prog_wait(11'h040, 8'h12, 8'h12);
    rd(11'h040, v); check("R3 decoder back in read mode", v, 8'h12);
  endtask

  task automatic t_sector();
    logic [7:0] f, v; int k;
    prog_wait(11'h155, 8'h11, 8'h11);
    prog_wait(11'h3AA, 8'h33, 8'h33);
    prog_wait(11'h5FE, 8'hD5, 8'hD5);
    erase_prefix();
    bus_wr(11'h100, 8'h30);
    bus_wr(11'h300, 8'h30);
    poll(11'h155, 8'hFF, 7000, f, k);
    n_chk++;
    if (k < SECT_CYC - 20 || k > SECT_CYC + WIN_CYC + 20) begin
      n_bad++;
      $display("FAIL R10 sector erase duration: actual %0d expected about %0d", k, SECT_CYC);
    end
    rd(11'h155, v); check("R7 first sector erased", v, 8'hFF);
    rd(11'h3AA, v); check("R7 second sector erased", v, 8'hFF);
    rd(11'h5FE, v); check("R7 other sector kept", v, 8'hD5);
  endtask

  task automatic t_cancel();
    logic [7:0] v;
    prog_wait(11'h410, 8'h44, 8'h44);
    erase_prefix();
    bus_wr(11'h410, 8'h30);
    bus_wr(11'h000, 8'h00);
    repeat (WIN_CYC + SECT_CYC / 2) @(negedge clk);
    rd(11'h410, v); check("R8 cancelled erase keeps data", v, 8'h44);
  endtask

  task automatic t_chip();
    logic [7:0] f, v; int k;
    prog_wait(11'h7FF, 8'h77, 8'h77);
    erase_prefix();
    bus_wr(11'h555, 8'h10);
    @(negedge clk); addr = 11'h5FE; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); f = dout; ce_n = 1'b1; oe_n = 1'b1;
    check("R6 erase status bit7 zero", f, 8'h00);
    cmd_prog(11'h020, 8'h00);
    poll(11'h5FE, 8'hFF, 8000, f, k);
    check("R6 chip erase finishes", (k > 0) ? 8'h01 : 8'h00, 8'h01);
    rd(11'h5FE, v); check("R6 chip erase clears byte", v, 8'hFF);
    rd(11'h7FF, v); check("R6 chip erase clears top byte", v, 8'hFF);
    rd(11'h410, v); check("R6 chip erase clears mid byte", v, 8'hFF);
    rd(11'h020, v); check("R9 program during busy ignored", v, 8'hFF);
    prog_wait(11'h021, 8'h9C, 8'h9C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ce_high();
    t_program();
    t_abort();
    t_sector();
    t_cancel();
    t_chip();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule